// File: doc/BRIEF.md
# Fault-Triggered Smart Shutdown Controller

This block manages the shutdown path of a half-bridge gate driver. It watches a fault comparator and a shared active-low shutdown line. That line is both driven by an external controller and pulled low by an on-chip open-drain device. When the comparator trips, both gate outputs are disabled through a single drive-enable bit. This happens at once, without waiting for the slow external RC network on the shared line to discharge.

During a trip the block also switches on the open-drain pull-down. It keeps the pull-down on until the shared line is read below its lower threshold. It then lets the line go, and the external network recharges it. Drive resumes only when the line is read above its upper threshold. The disable time therefore follows the external RC values, while the protection delay does not depend on them.

A low level applied to the line from outside also disables drive, but the block does not latch it. This allows PWM chopping through the shutdown pin. All three inputs are asynchronous threshold bits that the block synchronizes itself.

Top module: `ssd_ctrl`

## Requirements
- R1: After reset, drv_en and od_pull are 0. Both stay 0, and a comparator trip has no effect, until the line is first read above the upper threshold (line_hi_raw=1).
- R2: A comparator trip (trip_raw=1) drives drv_en low, and od_pull high, on the second rising clock edge after the input changes. drv_en is still high after the first edge.
- R3: Once on, od_pull stays on while the line is read above the lower threshold (line_lo_raw=1). It stays on even after the trip has cleared.
- R4: With the trip clear, od_pull turns off on the third rising edge after line_lo_raw goes to 0.
- R5: drv_en rises on the third rising edge after line_hi_raw goes to 1, provided no trip is present and no pull-down hold is active.
- R6: An external low on the line (line_lo_raw=0) drives drv_en low without turning on od_pull. The block does not latch it: when the line is read high again, drive returns.
- R7: The line state has hysteresis. When the line is between the thresholds (line_lo_raw=1, line_hi_raw=0), the previous state holds: drive stays enabled after a fall from high, and stays disabled after a rise from low.
- R8: A trip that arrives while the pull-down hold is active has no further effect. The hold still ends when the lower-threshold condition is seen.
- R9: If the trip is still present when the line falls below the lower threshold, od_pull stays on. It turns off on the third rising edge after trip_raw clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| trip_raw | input | 1 | Fault comparator output, asynchronous, 1 = tripped |
| line_hi_raw | input | 1 | Shared line above upper threshold, asynchronous |
| line_lo_raw | input | 1 | Shared line above lower threshold, asynchronous |
| od_pull | output | 1 | Open-drain pull-down enable, 1 = pull line low |
| drv_en | output | 1 | Gate-drive enable for both outputs, 1 = follow logic inputs |

## Verification
A trip reaches drv_en and od_pull on the second rising edge, because it passes only through the two synchronizer flops before reaching combinational output logic. Threshold changes on the line take effect on the third edge, because the line state register and the state machine add one more stage. The bench drives every input on a falling edge. For each result it checks the output on the falling edge just before its due edge, then on the falling edge just after it. A delay that is one cycle early or one cycle late is therefore reported.

// File: rtl/ssd_pkg.sv
package ssd_pkg;
  typedef enum logic [1:0] {
    ST_INIT = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } ssd_state_e;

  localparam int unsigned SSD_NUM_IN = 3;
  localparam int unsigned SSD_IDX_TRIP = 0;
  localparam int unsigned SSD_IDX_HI   = 1;
  localparam int unsigned SSD_IDX_LO   = 2;
endpackage

// File: rtl/ssd_rst_sync.sv
module ssd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_s_n = chain_q[STAGES-1];
endmodule

// File: rtl/ssd_sync.sv
module ssd_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        always_comb stage_d = d_async;
      end else begin : g_next
        always_comb stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/ssd_line_hyst.sv
module ssd_line_hyst (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_s,
  input  logic lo_s,
  output logic line_ok
);
  logic ok_q;
  logic ok_d;
  logic ok_en;

  always_comb begin
    ok_en = !lo_s || hi_s;
    ok_d  = lo_s && hi_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ok_q <= 1'b0;
    else if (ok_en) ok_q <= ok_d;
  end

  assign line_ok = ok_q;

  assert_low_stays_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ok_q && !hi_s) |=> !ok_q);
  assert_high_stays_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_q && lo_s) |=> ok_q);
  assert_below_lower_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_s |=> !ok_q);
endmodule

// File: rtl/ssd_fault_fsm.sv
module ssd_fault_fsm
  import ssd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic trip_s,
  input  logic hi_s,
  input  logic lo_s,
  input  logic line_ok,
  output logic od_pull,
  output logic drv_en
);
  ssd_state_e state_q;
  ssd_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_INIT: if (hi_s && lo_s)        state_d = ST_RUN;
      ST_RUN:  if (trip_s)              state_d = ST_HOLD;
      ST_HOLD: if (!lo_s && !trip_s)    state_d = ST_RUN;
      default:                          state_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_INIT;
    else        state_q <= state_d;
  end

  always_comb begin
    od_pull = (state_q == ST_HOLD) || ((state_q == ST_RUN) && trip_s);
    drv_en  = (state_q == ST_RUN) && line_ok && !trip_s;
  end

  assert_init_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_INIT) |-> (!od_pull && !drv_en));
  assert_hold_above_lower_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (od_pull && lo_s) |=> od_pull);
  assert_release_below_lower_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && !lo_s && !trip_s) |=> (state_q == ST_RUN));
  assert_trip_keeps_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && trip_s) |=> (state_q == ST_HOLD));
endmodule

// File: rtl/ssd_ctrl.sv
module ssd_ctrl
  import ssd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_raw,
  input  logic line_hi_raw,
  input  logic line_lo_raw,
  output logic od_pull,
  output logic drv_en
);
  logic                  rst_s_n;
  logic [SSD_NUM_IN-1:0] raw_vec;
  logic [SSD_NUM_IN-1:0] syn_vec;
  logic                  trip_s;
  logic                  hi_s;
  logic                  lo_s;
  logic                  line_ok;

  ssd_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  always_comb begin
    raw_vec               = '0;
    raw_vec[SSD_IDX_TRIP] = trip_raw;
    raw_vec[SSD_IDX_HI]   = line_hi_raw;
    raw_vec[SSD_IDX_LO]   = line_lo_raw;
  end

  ssd_sync #(.WIDTH(SSD_NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .d_async (raw_vec),
    .q_sync  (syn_vec)
  );

  assign trip_s = syn_vec[SSD_IDX_TRIP];
  assign hi_s   = syn_vec[SSD_IDX_HI];
  assign lo_s   = syn_vec[SSD_IDX_LO];

  ssd_line_hyst u_hyst (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .hi_s    (hi_s),
    .lo_s    (lo_s),
    .line_ok (line_ok)
  );

  ssd_fault_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .trip_s  (trip_s),
    .hi_s    (hi_s),
    .lo_s    (lo_s),
    .line_ok (line_ok),
    .od_pull (od_pull),
    .drv_en  (drv_en)
  );

  assert_trip_blocks_drive_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    trip_s |-> !drv_en);
  assert_pull_blocks_drive_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    od_pull |-> !drv_en);
  assert_drive_needs_line_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    drv_en |-> line_ok);
endmodule

// File: tb/ssd_ctrl_tb.sv
module ssd_ctrl_tb;
  logic clk;
  logic rst_n;
  logic trip_raw;
  logic line_hi_raw;
  logic line_lo_raw;
  logic od_pull;
  logic drv_en;

  int n_checks;
  int n_errors;

  ssd_ctrl u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .trip_raw    (trip_raw),
    .line_hi_raw (line_hi_raw),
    .line_lo_raw (line_lo_raw),
    .od_pull     (od_pull),
    .drv_en      (drv_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic exp_od, input logic exp_drv);
    n_checks++;
    if (od_pull !== exp_od || drv_en !== exp_drv) begin
      n_errors++;
      $display("FAIL %s: od_pull=%b drv_en=%b expected od_pull=%b drv_en=%b",
               req, od_pull, drv_en, exp_od, exp_drv);
    end
  endtask

  // line levels: high = above both thresholds, mid = between, low = below both
  task automatic line_high(); line_hi_raw = 1'b1; line_lo_raw = 1'b1; endtask
  task automatic line_mid();  line_hi_raw = 1'b0; line_lo_raw = 1'b1; endtask
  task automatic line_low();  line_hi_raw = 1'b0; line_lo_raw = 1'b0; endtask

  task automatic t_reset_R1();
    rst_n = 1'b0; trip_raw = 1'b0; line_low();
    step(4);
    rst_n = 1'b1;
    step(4);
    check("R1 reset", 1'b0, 1'b0);
    trip_raw = 1'b1; step(4);
    check("R1 trip before arm", 1'b0, 1'b0);
    trip_raw = 1'b0; line_mid(); step(4);
    check("R1 mid before arm", 1'b0, 1'b0);
    line_high(); step(2);
    check("R5 not yet at edge 2", 1'b0, 1'b0);
    step(1);
    check("R5 drive on at edge 3", 1'b0, 1'b1);
  endtask

  task automatic t_trip_hold_R2_R3_R4_R8();
    trip_raw = 1'b1; step(1);
    check("R2 still on after edge 1", 1'b0, 1'b1);
    step(1);
    check("R2 off at edge 2", 1'b1, 1'b0);
    trip_raw = 1'b0; step(5);
    check("R3 hold after trip clears", 1'b1, 1'b0);
    line_mid(); step(5);
    check("R3 hold between thresholds", 1'b1, 1'b0);
    trip_raw = 1'b1; step(3); trip_raw = 1'b0; step(3);
    check("R8 trip during hold", 1'b1, 1'b0);
    line_low(); step(2);
    check("R4 still held at edge 2", 1'b1, 1'b0);
    step(1);
    check("R4 released at edge 3", 1'b0, 1'b0);
    line_mid(); step(5);
    check("R7 rising mid stays off", 1'b0, 1'b0);
    line_high(); step(2);
    check("R5 not yet after release", 1'b0, 1'b0);
    step(1);
    check("R5 drive resumes", 1'b0, 1'b1);
  endtask

  task automatic t_trip_persist_R9();
    trip_raw = 1'b1; step(3);
    check("R9 tripped", 1'b1, 1'b0);
    line_low(); step(5);
    check("R9 held while trip present", 1'b1, 1'b0);
    trip_raw = 1'b0; step(2);
    check("R9 held at edge 2", 1'b1, 1'b0);
    step(1);
    check("R9 released at edge 3", 1'b0, 1'b0);
    line_high(); step(3);
    check("R9 drive back", 1'b0, 1'b1);
  endtask

  task automatic t_external_R6_R7();
    line_mid(); step(5);
    check("R7 falling mid stays on", 1'b0, 1'b1);
    line_high(); step(3);
    for (int k = 0; k < 3; k++) begin
      line_low(); step(2);
      check("R6 chop off not yet", 1'b0, 1'b1);
      step(1);
      check("R6 chop off", 1'b0, 1'b0);
      step(3);
      check("R6 no pull-down", 1'b0, 1'b0);
      line_high(); step(3);
      check("R6 not latched", 1'b0, 1'b1);
    end
  endtask

  initial begin
    n_checks = 0;
    n_errors = 0;
    t_reset_R1();
    t_trip_hold_R2_R3_R4_R8();
    t_trip_persist_R9();
    t_external_R6_R7();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #1000000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule